// File: doc/BRIEF.md
# Debounced Change Notification Gate

This block sits behind an input scanner and decides when the input changes it has collected may be handed to the consumer. Each time the scanner finishes a pass it raises a one-cycle strobe together with a mask of the bits that moved during that pass. The gate ORs those bits into a set of pending change flags. It also runs a countdown that restarts from a programmable preload on every pass that shows movement. On passes with no movement the countdown steps down by one.

A notification can only be raised while the countdown is at zero. As a result, the first movement after a quiet period is reported at once. Further movements inside the hold window are kept, and they are reported together once the window has run out. A preload of zero turns the hold window off. A notification presents the collected mask with a valid flag and keeps it unchanged until the consumer acknowledges it. Movements that arrive while a notification waits for acknowledgement are kept for the next one.

Top module: `debounce_notify_gate`

## Requirements
- R1: After reset, `notify_valid` is low, `notify_mask` is all zero and the hold countdown is at zero, so the gate is open.
- R2: With `preload` at 0, a nonzero `change_vec` sampled with `scan_done` is presented on the clock edge that samples it: `notify_valid` is high in the next cycle, and `notify_mask` equals that change mask.
- R3: A movement seen while the countdown is zero and no notification is outstanding is reported on the same edge, even when `preload` is nonzero. That edge loads the countdown with `preload`.
- R4: Every scan with a nonzero change mask reloads the countdown with `preload`, which restarts the hold window.
- R5: A scan with no movement lowers a nonzero countdown by exactly one. Cycles without `scan_done` leave the countdown unchanged.
- R6: While the countdown is nonzero, `notify_valid` does not rise. Changes arriving in that time are ORed into the pending flags.
- R7: When a scan brings the countdown to zero and no notification is outstanding, the pending flags are presented on the following clock edge, without waiting for another scan.
- R8: While `notify_valid` is high and `notify_ack` is low, `notify_valid` and `notify_mask` stay unchanged. An acknowledge drops `notify_valid` and clears the mask on the next edge. Changes that arrive during the presentation are reported afterwards.
- R9: No movement is lost: the masks reported, taken together, cover every bit that was seen moving.
- R10: `change_vec` has no effect while `scan_done` is low.
- R11: A scan whose change mask is all zero counts as a pass without movement. It steps the countdown and does not reload it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_done | input | 1 | One-cycle strobe at the end of each scan pass |
| change_vec | input | WIDTH | Bits that moved during the pass; sampled only with `scan_done` |
| preload | input | CNT_W | Hold-window reload value in scan passes; 0 disables the hold |
| notify_ack | input | 1 | Consumer acknowledge of the presented mask |
| notify_valid | output | 1 | A change mask is being presented |
| notify_mask | output | WIDTH | Collected change flags being reported |

## Verification
The hardest case to reach from the ports is the exact scan on which a long hold window expires. The countdown is internal, so its value can only be inferred from when a notification appears. The stimulus therefore acknowledges the first report and then moves a second bit, which reloads the window. It then issues a counted number of empty scans with idle cycles between them. The bench checks that nothing is reported one scan before expiry and that the report appears exactly one edge after the last empty scan. This is done with a small preload and with the largest preload, 255.

// File: rtl/dng_pkg.sv
package dng_pkg;

  // What the hold countdown does on a given cycle.
  typedef enum logic [1:0] {
    CA_HOLD = 2'd0,
    CA_LOAD = 2'd1,
    CA_DEC  = 2'd2
  } cnt_act_e;

  // Movement always restarts the window; an empty scan steps it down
  // only while it is still running; everything else keeps the value.
  function automatic cnt_act_e dng_count_action(input logic scan,
                                                input logic moved,
                                                input logic at_zero);
    cnt_act_e act;
    act = CA_HOLD;
    if (scan && moved)         act = CA_LOAD;
    else if (scan && !at_zero) act = CA_DEC;
    return act;
  endfunction

endpackage

// File: rtl/dng_countdown.sv
module dng_countdown
  import dng_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan,
  input  logic             moved,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             gate_open
);

  logic [CNT_W-1:0] count_q;
  cnt_act_e         act;

  assign act       = dng_count_action(scan, moved, count_q == '0);
  assign count     = count_q;
  assign gate_open = (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      case (act)
        CA_LOAD: count_q <= preload;
        CA_DEC:  count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_RELOAD_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    scan && moved |=> count == $past(preload)); // R4

  AST_STEP_ON_EMPTY_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    scan && !moved && count != '0 |=> count == $past(count) - 1'b1); // R5

  AST_IDLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !scan |=> $stable(count)); // R5

  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 && !(scan && moved) |=> count == '0); // R11

endmodule

// File: rtl/dng_accum.sv
module dng_accum #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] incoming,
  input  logic             take,
  output logic [WIDTH-1:0] pending,
  output logic [WIDTH-1:0] merged
);

  logic [WIDTH-1:0] pend_q;

  function automatic logic [WIDTH-1:0] dng_union(input logic [WIDTH-1:0] a,
                                                 input logic [WIDTH-1:0] b);
    return a | b;
  endfunction

  assign merged  = dng_union(pend_q, incoming);
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= '0;
    else if (take) pend_q <= '0;
    else           pend_q <= merged;
  end

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (pending & $past(pending)) == $past(pending)); // R9

  AST_NEW_FLAG_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (pending & $past(incoming)) == $past(incoming)); // R6

endmodule

// File: rtl/dng_present.sv
module dng_present #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_open,
  input  logic [WIDTH-1:0] merged,
  input  logic             ack,
  output logic             take,
  output logic             valid,
  output logic [WIDTH-1:0] mask
);

  logic             valid_q;
  logic [WIDTH-1:0] mask_q;

  assign take  = gate_open && !valid_q && (merged != '0);
  assign valid = valid_q;
  assign mask  = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      mask_q  <= merged;
    end else if (valid_q && ack) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ack |=> valid && $stable(mask)); // R8

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ack |=> !valid && mask == '0); // R8

  AST_NO_RISE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(gate_open)); // R6

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> mask != '0); // R9

endmodule

// File: rtl/debounce_notify_gate.sv
module debounce_notify_gate #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_done,
  input  logic [WIDTH-1:0] change_vec,
  input  logic [CNT_W-1:0] preload,
  input  logic             notify_ack,
  output logic             notify_valid,
  output logic [WIDTH-1:0] notify_mask
);

  // Named internal events, visible to the assertions.
  logic [WIDTH-1:0] incoming;
  logic             moved;
  logic             gate_open;
  logic             take;
  logic [CNT_W-1:0] hold_count;
  logic [WIDTH-1:0] pending;
  logic [WIDTH-1:0] merged;

  // Changes count only on a scan strobe.
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_qual
    assign incoming[gi] = change_vec[gi] & scan_done;
  end

  assign moved = (incoming != '0);

  dng_countdown #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan      (scan_done),
    .moved     (moved),
    .preload   (preload),
    .count     (hold_count),
    .gate_open (gate_open)
  );

  dng_accum #(.WIDTH(WIDTH)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .incoming (incoming),
    .take     (take),
    .pending  (pending),
    .merged   (merged)
  );

  dng_present #(.WIDTH(WIDTH)) u_present (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_open (gate_open),
    .merged    (merged),
    .ack       (notify_ack),
    .take      (take),
    .valid     (notify_valid),
    .mask      (notify_mask)
  );

  AST_IDLE_INPUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done && !take |=> $stable(pending)); // R10

  AST_PRELOAD_ZERO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    preload == '0 && $past(preload) == '0 |-> hold_count == '0); // R2

  AST_FIRST_MOVE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    take && moved |=> hold_count == $past(preload)); // R3

endmodule

// File: tb/test_debounce_notify_gate.sv
module test_debounce_notify_gate;

  localparam int WIDTH = 16;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scan_done = 1'b0;
  logic [WIDTH-1:0] change_vec = '0;
  logic [CNT_W-1:0] preload = '0;
  logic             notify_ack = 1'b0;
  logic             notify_valid;
  logic [WIDTH-1:0] notify_mask;

  int n_chk  = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] exp_q[$];
  logic             prev_valid = 1'b0;
  logic             mon_on = 1'b0;
  logic             done = 1'b0;

  always #5 clk = ~clk;

  debounce_notify_gate #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_debounce_notify_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_done    (scan_done),
    .change_vec   (change_vec),
    .preload      (preload),
    .notify_ack   (notify_ack),
    .notify_valid (notify_valid),
    .notify_mask  (notify_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic scan(input logic [WIDTH-1:0] m);
    @(negedge clk);
    scan_done  = 1'b1;
    change_vec = m;
    @(negedge clk);
    scan_done  = 1'b0;
    change_vec = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    notify_ack = 1'b1;
    @(negedge clk);
    notify_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: each new presentation pops one expected mask.
  always @(negedge clk) begin
    if (mon_on && notify_valid && !prev_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected report", {16'h0, notify_mask}, 32'h0);
      end else begin
        check("R9 reported mask", {16'h0, notify_mask}, {16'h0, exp_q.pop_front()});
      end
    end
    prev_valid = notify_valid;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 valid after reset", {31'h0, notify_valid}, 32'h0);
    check("R1 mask after reset", {16'h0, notify_mask}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(1);

    // No hold window.
    preload = 8'd0;
    exp_q.push_back(16'h0001);
    scan(16'h0001);
    check("R2 valid on scan edge", {31'h0, notify_valid}, 32'h1);
    check("R2 mask", {16'h0, notify_mask}, 32'h0001);
    ack();
    check("R8 ack drops valid", {31'h0, notify_valid}, 32'h0);

    exp_q.push_back(16'h8000);
    exp_q.push_back(16'h0010);
    scan(16'h8000);
    check("R2 second report", {31'h0, notify_valid}, 32'h1);
    scan(16'h0010);
    idle(2);
    check("R8 mask held without ack", {16'h0, notify_mask}, 32'h8000);
    ack();
    check("R8 low after ack", {31'h0, notify_valid}, 32'h0);
    idle(1);
    check("R8 late change follows", {31'h0, notify_valid}, 32'h1);
    check("R8 late change mask", {16'h0, notify_mask}, 32'h0010);
    ack();

    // Change vector without a strobe must not be seen.
    @(negedge clk);
    change_vec = 16'hFFFF;
    idle(3);
    change_vec = '0;
    idle(2);
    check("R10 no strobe no report", {31'h0, notify_valid}, 32'h0);

    // Hold window of 3 scans.
    preload = 8'd3;
    idle(1);
    exp_q.push_back(16'h0002);
    scan(16'h0002);
    check("R3 first move immediate", {31'h0, notify_valid}, 32'h1);
    ack();
    scan(16'h0004);
    check("R6 held during window", {31'h0, notify_valid}, 32'h0);
    scan(16'h0000);
    scan(16'h0008);
    scan(16'h0000);
    scan(16'h0000);
    idle(5);
    check("R4 reload extends window", {31'h0, notify_valid}, 32'h0);
    check("R5 idle cycles do not count", {31'h0, notify_valid}, 32'h0);
    exp_q.push_back(16'h000C);
    scan(16'h0000);
    check("R11 zero mask scan steps to zero", {31'h0, notify_valid}, 32'h0);
    idle(1);
    check("R7 report after expiry", {31'h0, notify_valid}, 32'h1);
    check("R6 accumulated mask", {16'h0, notify_mask}, 32'h000C);
    ack();

    // Largest hold window.
    preload = 8'd255;
    idle(1);
    exp_q.push_back(16'h1000);
    scan(16'h1000);
    check("R3 immediate at max preload", {31'h0, notify_valid}, 32'h1);
    ack();
    scan(16'h2000);
    for (int k = 0; k < 254; k++) scan(16'h0000);
    idle(2);
    check("R5 one scan before expiry", {31'h0, notify_valid}, 32'h0);
    exp_q.push_back(16'h2000);
    scan(16'h0000);
    idle(1);
    check("R7 report at max preload", {31'h0, notify_valid}, 32'h1);
    check("R7 mask at max preload", {16'h0, notify_mask}, 32'h2000);
    ack();
    idle(2);

    check("R9 all expected reports seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule